// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames: one start bit, eight data bits sent least significant bit first, an optional ninth data bit, and a stop bit. The receiver runs on a baud tick at sixteen times the bit rate. The block selects that tick from one of two sources. One is an external baud generator. The other is a timer overflow, which is halved unless a double-speed control is set. At the middle of each bit the receiver takes three samples and decides the bit by majority vote. At the stop bit it loads the received byte and the ninth bit into output registers. It also raises sticky status flags for receive-complete and framing error. Software clears these flags with strobes.

A separate detector watches for a break, meaning the line held low for eleven bit times in a row. It raises a sticky break flag once for each low period. It does not report again until the line has gone high. When enabled, a detected break also sends a one-cycle reset request. A select input sets what bit 7 of the serial control register shows: the framing-error flag or the stored mode bit.

The frame state machine has five states. IDLE waits for a falling edge and moves to START. START returns to IDLE if the mid-bit vote reads high (false start). Otherwise START moves to DATA at the end of the bit. DATA moves on after the last data bit, to NINTH in 9-bit mode or to STOP in 8-bit mode. NINTH moves to STOP at the end of the bit. STOP returns to IDLE right at its mid-bit vote, which is when the frame is reported.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, rx_done, fe_flag, brk_flag and reset_req are 0, and rx_data is 0.
- R2: A low pulse on rxd that has ended before the middle of the start bit returns the receiver to IDLE. It sets no flag.
- R3: Each bit is the majority of three samples taken at oversample points 7, 8 and 9. A one-clock glitch in the middle of a bit does not change the received value. Data arrives least significant bit first. rx_done is set at the stop-bit sample.
- R4: With nine_mode=1, the bit after the eight data bits is stored in rx_bit8. With nine_mode=0, rx_bit8 is loaded with 0 when each frame completes.
- R5: A stop bit sampled low sets fe_flag. A stop bit sampled high leaves fe_flag at 0.
- R6: rx_done, fe_flag and brk_flag stay set until their clear strobe (clr_done, clr_fe, clr_brk) is high at a clock edge.
- R7: brk_flag is set once rxd has been low for 11 consecutive bit times. A low period of 10 bit times does not set it.
- R8: One unbroken low period produces exactly one break event, however long it lasts. Break detection is armed again only after the line has been high.
- R9: When brk_rst_en=1, a break event produces a reset_req pulse of exactly one cycle. When brk_rst_en=0, reset_req stays 0.
- R10: scon7 shows fe_flag when fe_sel=1 and shows sm0_bit when fe_sel=0.
- R11: With sel_gen=1, every gen_tick is a baud tick. With sel_gen=0 and dbl_speed=1, every t1_ovf is a tick. With sel_gen=0 and dbl_speed=0, every second t1_ovf is a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| sel_gen | input | 1 | 1: tick from gen_tick; 0: tick from t1_ovf |
| gen_tick | input | 1 | Pulse from the independent baud generator |
| t1_ovf | input | 1 | Timer overflow pulse |
| dbl_speed | input | 1 | 1: use every timer overflow; 0: use every second one |
| nine_mode | input | 1 | 1: frames carry a ninth data bit |
| fe_sel | input | 1 | Selects what scon7 shows |
| sm0_bit | input | 1 | Stored mode bit shown on scon7 when fe_sel=0 |
| brk_rst_en | input | 1 | Enables the reset request on a break |
| clr_done | input | 1 | Clears rx_done |
| clr_fe | input | 1 | Clears fe_flag |
| clr_brk | input | 1 | Clears brk_flag |
| rx_data | output | DATA_W | Last received data byte |
| rx_bit8 | output | 1 | Last received ninth bit |
| rx_done | output | 1 | Sticky receive-complete flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| brk_flag | output | 1 | Sticky break flag |
| scon7 | output | 1 | Control register bit 7 view |
| reset_req | output | 1 | One-cycle reset request on a break |

## Verification
The bench uses the default parameters: 16 oversamples, 8 data bits and an 11-bit break threshold. With gen_tick held high, one bit lasts 16 clocks, so a break is detected after about 176 cycles and a 25-bit low period stays well inside the budget. With t1_ovf held high, dbl_speed=0 gives 32-clock bits and dbl_speed=1 gives 16-clock bits. A frame therefore decodes correctly only if the tick divider behaves as R11 states. The directed cases cover:
- exactly 10 low bit times (no break expected);
- a single-clock glitch at mid-bit (majority vote must reject it);
- a break with the reset request disabled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/rx_tick_sel.sv
module rx_tick_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_gen,
    input  logic gen_tick,
    input  logic t1_ovf,
    input  logic dbl_speed,
    output logic tick
);
    logic half_q;

    // half_q toggles on every overflow; in half-speed mode only odd overflows pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            half_q <= 1'b0;
        else if (t1_ovf)
            half_q <= ~half_q;
    end

    always_comb begin
        if (sel_gen)
            tick = gen_tick;
        else if (dbl_speed)
            tick = t1_ovf;
        else
            tick = t1_ovf & half_q;
    end
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic brk_pulse
);
    localparam int BRK_TICKS = BRK_BITS * OVS;
    localparam int BRK_W     = $clog2(BRK_TICKS + 1);

    logic [BRK_W-1:0] low_cnt;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            armed     <= 1'b1;
            brk_pulse <= 1'b0;
        end else begin
            brk_pulse <= 1'b0;
            if (line) begin
                low_cnt <= '0;
                armed   <= 1'b1;
            end else if (tick && armed) begin
                if (low_cnt == BRK_W'(BRK_TICKS - 1)) begin
                    brk_pulse <= 1'b1;
                    armed     <= 1'b0;
                    low_cnt   <= '0;
                end else begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              nine_mode,
    output rx_state_t         state_o,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_bit8,
    output logic              frame_stop
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MID   = OVS / 2;

    rx_state_t         state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              bit8_q;
    logic              s_a, s_b;
    logic              line_q;
    logic              fall, at_vote, at_end, vote, last_bit;

    assign fall     = line_q & ~line;
    assign at_vote  = tick && (cnt == CNT_W'(MID + 1));
    assign at_end   = tick && (cnt == CNT_W'(OVS - 1));
    assign vote     = (s_a & s_b) | (s_a & line) | (s_b & line);
    assign last_bit = (idx == IDX_W'(DATA_W - 1));
    assign state_o  = state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (fall) state_n = ST_START;
            ST_START: begin
                if (at_vote && vote)
                    state_n = ST_IDLE;
                else if (at_end)
                    state_n = ST_DATA;
            end
            ST_DATA:  if (at_end && last_bit) state_n = nine_mode ? ST_NINTH : ST_STOP;
            ST_NINTH: if (at_end) state_n = ST_STOP;
            ST_STOP:  if (at_vote) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            bit8_q     <= 1'b0;
            s_a        <= 1'b1;
            s_b        <= 1'b1;
            line_q     <= 1'b1;
            frame_done <= 1'b0;
            frame_data <= '0;
            frame_bit8 <= 1'b0;
            frame_stop <= 1'b1;
        end else begin
            line_q     <= line;
            frame_done <= 1'b0;
            if (state == ST_IDLE) begin
                cnt <= '0;
                idx <= '0;
            end else if (tick) begin
                cnt <= (cnt == CNT_W'(OVS - 1)) ? '0 : cnt + 1'b1;
                if (cnt == CNT_W'(MID - 1)) s_a <= line;
                if (cnt == CNT_W'(MID))     s_b <= line;
            end
            unique case (state)
                ST_DATA: begin
                    if (at_vote) shreg <= {vote, shreg[DATA_W-1:1]};
                    if (at_end)  idx   <= idx + 1'b1;
                end
                ST_NINTH: if (at_vote) bit8_q <= vote;
                ST_STOP: begin
                    if (at_vote) begin
                        frame_done <= 1'b1;
                        frame_data <= shreg;
                        frame_bit8 <= nine_mode ? bit8_q : 1'b0;
                        frame_stop <= vote;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DATA_W   = 8,
    parameter int BRK_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              sel_gen,
    input  logic              gen_tick,
    input  logic              t1_ovf,
    input  logic              dbl_speed,
    input  logic              nine_mode,
    input  logic              fe_sel,
    input  logic              sm0_bit,
    input  logic              brk_rst_en,
    input  logic              clr_done,
    input  logic              clr_fe,
    input  logic              clr_brk,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              fe_flag,
    output logic              brk_flag,
    output logic              scon7,
    output logic              reset_req
);
    logic              sync1, line_s;
    logic              tick;
    logic              brk_pulse;
    logic              f_done, f_bit8, f_stop;
    logic [DATA_W-1:0] f_data;
    rx_state_t         fsm_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1  <= 1'b1;
            line_s <= 1'b1;
        end else begin
            sync1  <= rxd;
            line_s <= sync1;
        end
    end

    rx_tick_sel u_tick (
        .clk(clk), .rst_n(rst_n), .sel_gen(sel_gen), .gen_tick(gen_tick),
        .t1_ovf(t1_ovf), .dbl_speed(dbl_speed), .tick(tick)
    );

    rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
        .nine_mode(nine_mode), .state_o(fsm_state), .frame_done(f_done),
        .frame_data(f_data), .frame_bit8(f_bit8), .frame_stop(f_stop)
    );

    rx_break_det #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
        .brk_pulse(brk_pulse)
    );

    // status register: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit8   <= 1'b0;
            rx_done   <= 1'b0;
            fe_flag   <= 1'b0;
            brk_flag  <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= brk_pulse & brk_rst_en;
            if (f_done) begin
                rx_data <= f_data;
                rx_bit8 <= f_bit8;
                rx_done <= 1'b1;
            end else if (clr_done) begin
                rx_done <= 1'b0;
            end
            if (f_done && !f_stop) fe_flag <= 1'b1;
            else if (clr_fe)       fe_flag <= 1'b0;
            if (brk_pulse)         brk_flag <= 1'b1;
            else if (clr_brk)      brk_flag <= 1'b0;
        end
    end

    assign scon7 = fe_sel ? fe_flag : sm0_bit;
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk
    import uart_rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      brk_rst_en,
    input logic      reset_req,
    input logic      brk_flag,
    input logic      fe_flag,
    input logic      rx_done,
    input logic      clr_brk,
    input logic      clr_fe,
    input logic      clr_done,
    input logic      line_s,
    input rx_state_t fsm_state
);
    assert_rst_req_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(brk_rst_en));
    assert_rst_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    assert_brk_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !clr_brk) |=> brk_flag);
    assert_fe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_flag && !clr_fe) |=> fe_flag);
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_done) |=> rx_done);
    assert_brk_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> !$past(line_s, 2));
    assert_done_from_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ($past(fsm_state, 2) == ST_STOP));
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .brk_rst_en(brk_rst_en), .reset_req(reset_req),
    .brk_flag(brk_flag), .fe_flag(fe_flag), .rx_done(rx_done),
    .clr_brk(clr_brk), .clr_fe(clr_fe), .clr_done(clr_done),
    .line_s(line_s), .fsm_state(fsm_state)
);

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1, sel_gen = 1'b1, gen_tick = 1'b1, t1_ovf = 1'b0, dbl_speed = 1'b0;
    logic nine_mode = 1'b0, fe_sel = 1'b0, sm0_bit = 1'b0, brk_rst_en = 1'b0;
    logic clr_done = 1'b0, clr_fe = 1'b0, clr_brk = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit8, rx_done, fe_flag, brk_flag, scon7, reset_req;

    int errors = 0, checks = 0, rr_pulses = 0, bclk = 16;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_brk dut (.*);

    always @(posedge clk) if (reset_req) rr_pulses <= rr_pulses + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rb8(input bit nine, input bit b9);
        return nine ? int'(b9) : 0;
    endfunction

    function automatic int exp_fe(input bit stopv);
        return stopv ? 0 : 1;
    endfunction

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        clr_done = 1; clr_fe = 1; clr_brk = 1;
        @(negedge clk);
        clr_done = 0; clr_fe = 0; clr_brk = 0;
    endtask

    task automatic set_mode(input int m);
        // 0: generator tick each clock; 1: timer halved; 2: timer double speed
        sel_gen   = (m == 0);
        gen_tick  = (m == 0);
        t1_ovf    = (m != 0);
        dbl_speed = (m == 2);
        bclk      = (m == 1) ? 32 : 16;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit b9, input bit stopv);
        hold(1'b0, bclk);
        for (int i = 0; i < 8; i++) hold(d[i], bclk);
        if (nine_mode) hold(b9, bclk);
        hold(stopv, bclk);
        hold(1'b1, 2 * bclk);
    endtask

    task automatic frame_check(input string tag, input logic [7:0] d, input bit b9, input bit stopv);
        clear_all();
        send_frame(d, b9, stopv);
        chk({tag, " R3 data"}, rx_data, d);
        chk({tag, " R3 done"}, rx_done, 1);
        chk({tag, " R4 rb8"}, rx_bit8, exp_rb8(nine_mode, b9));
        chk({tag, " R5 fe"}, fe_flag, exp_fe(stopv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", rx_done, 0);
        chk("R1 fe", fe_flag, 0);
        chk("R1 brk", brk_flag, 0);
        chk("R1 rst_req", reset_req, 0);
        chk("R1 data", rx_data, 0);

        // R11 each tick source
        set_mode(0); hold(1'b1, 40);
        frame_check("R11 gen", 8'hA5, 0, 1);
        set_mode(1); hold(1'b1, 40);
        frame_check("R11 half", 8'h3C, 0, 1);
        set_mode(2); hold(1'b1, 40);
        frame_check("R11 dbl", 8'hC3, 0, 1);
        set_mode(0); hold(1'b1, 40);

        // R4 ninth bit
        nine_mode = 1;
        frame_check("R4 nine1", 8'h12, 1, 1);
        frame_check("R4 nine0", 8'h34, 0, 1);
        nine_mode = 0;
        frame_check("R4 eight", 8'h56, 0, 1);

        // R2 false start
        clear_all();
        hold(1'b0, 4);
        hold(1'b1, 4 * bclk);
        chk("R2 done", rx_done, 0);
        chk("R2 fe", fe_flag, 0);
        frame_check("R2 after", 8'h81, 0, 1);

        // R3 single-clock glitch at mid-bit
        clear_all();
        hold(1'b0, bclk);
        hold(1'b1, bclk/2); hold(1'b0, 1); hold(1'b1, bclk - bclk/2 - 1);
        for (int i = 1; i < 8; i++) hold(1'b0, bclk);
        hold(1'b1, bclk);
        hold(1'b1, 2 * bclk);
        chk("R3 glitch", rx_data, 8'h01);

        // R6 sticky until cleared
        hold(1'b1, 50);
        chk("R6 done held", rx_done, 1);
        clr_done = 1; @(negedge clk); clr_done = 0;
        chk("R6 done cleared", rx_done, 0);

        // R5 / R10 framing error and control bit view
        frame_check("R5 fe", 8'hF0, 0, 0);
        fe_sel = 1; sm0_bit = 0; @(negedge clk);
        chk("R10 sel fe", scon7, 1);
        fe_sel = 0; @(negedge clk);
        chk("R10 sm0=0", scon7, 0);
        sm0_bit = 1; @(negedge clk);
        chk("R10 sm0=1", scon7, 1);
        hold(1'b1, 30);
        chk("R6 fe held", fe_flag, 1);

        // R7 ten bit times low: no break
        clear_all();
        rr_pulses = 0; brk_rst_en = 1;
        send_frame(8'h00, 0, 0);
        chk("R7 short", brk_flag, 0);
        chk("R7 short rr", rr_pulses, 0);

        // R7 / R9 break with reset request
        clear_all();
        rr_pulses = 0;
        hold(1'b0, 12 * bclk);
        hold(1'b1, 2 * bclk);
        chk("R7 brk", brk_flag, 1);
        chk("R9 rr pulse", rr_pulses, 1);

        // R8 long low period reports once
        clear_all();
        rr_pulses = 0;
        hold(1'b0, 25 * bclk);
        hold(1'b1, 2 * bclk);
        chk("R8 once", rr_pulses, 1);
        chk("R8 brk", brk_flag, 1);

        // R9 disabled request
        clear_all();
        rr_pulses = 0; brk_rst_en = 0;
        hold(1'b0, 12 * bclk);
        hold(1'b1, 2 * bclk);
        chk("R9 disabled rr", rr_pulses, 0);
        chk("R9 disabled brk", brk_flag, 1);

        // random frames across tick modes and frame sizes
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            bit b9, sv;
            set_mode(int'($urandom_range(0, 2)));
            nine_mode = 1'($urandom_range(0, 1));
            d  = 8'($urandom);
            b9 = 1'($urandom_range(0, 1));
            sv = ($urandom_range(0, 3) != 0);
            if (!sv) d[7] = 1'b1;
            hold(1'b1, 40);
            frame_check("R3 rand", d, b9, sv);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule